// File: doc/BRIEF.md
# BCD Calendar Time Counter

The block keeps a calendar clock of seconds, minutes, hours, day of week, day of month, month and two-digit year. It moves forward by one second for each pulse of a 1 Hz enable. It rolls the date over correctly, including the Gregorian leap rule, with the full year taken as 2000 plus the stored two-digit year. The time is kept internally in binary. A set of visible byte registers presents it, encoded as packed BCD or as plain binary and in 12-hour or 24-hour form, under two mode bits.

Each accepted second first raises an update-in-progress flag. The visible registers are refreshed from the counter only after a fixed window of `UIP_CYCLES` clock cycles, so that software polling the flag never reads a half-updated time. The counter moves only while the oscillator control field holds the run code. A set-mode input freezes the visible registers while the counter keeps going. Software writes the time through a load strobe that carries seven encoded bytes. These are decoded with the current mode bits.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the visible registers read sec=0x00, min=0x00, hour=0x00, wday=0x00, mday=0x01, mon=0x01, year=0x00, and uip_o is low.
- R2: With bin_i low every visible byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With bin_i high it is the plain binary value.
- R3: With h24_i high the hour byte encodes 0..23. With h24_i low it encodes the hour modulo 12 in bits 6:0, and bit 7 is set for hours 12 to 23. Loaded hour bytes are decoded the same way.
- R4: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. At the day change the day of week goes from 6 to 0 and otherwise increments.
- R5: The day of month returns to 1 after the month's last day. Months 4, 6, 9 and 11 have 30 days, and February has 29 days when 2000+year is divisible by 4 and either not divisible by 100 or divisible by 400, otherwise 28. Other months have 31 days. The month goes from 12 back to 1, and the year goes from 99 back to 0.
- R6: A tick_i pulse advances the time only when osc_sel_i equals 3'b010. Otherwise it is ignored and uip_o stays low.
- R7: An accepted tick with set_i low sets uip_o in the next cycle. uip_o stays high for UIP_CYCLES cycles. The visible registers take the new time on the same edge at which uip_o falls.
- R8: While set_i is high, an accepted tick advances the internal time, but it neither raises uip_o nor changes the visible registers. A later refresh shows the time including those seconds.
- R9: A load_i pulse writes the seven bytes to the visible registers on the next edge. It sets the counter to their decoded value under the current mode bits, and it cancels a pending update so that uip_o is low afterwards. It takes precedence over a tick in the same cycle.
- R10: Without a load and outside the update window, the visible registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second enable, one cycle wide |
| osc_sel_i | input | 3 | Oscillator control field, 3'b010 means run |
| set_i | input | 1 | Set mode, freezes visible registers |
| bin_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| load_i | input | 1 | Write the time from the load bytes |
| ld_sec_i | input | 8 | Encoded seconds to load |
| ld_min_i | input | 8 | Encoded minutes to load |
| ld_hour_i | input | 8 | Encoded hour to load |
| ld_wday_i | input | 8 | Day of week to load, 0..6 |
| ld_mday_i | input | 8 | Encoded day of month to load |
| ld_mon_i | input | 8 | Encoded month to load, 1..12 |
| ld_year_i | input | 8 | Encoded two-digit year to load |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hour |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| year_o | output | 8 | Visible year |
| uip_o | output | 1 | Update in progress |

## Verification
The assertions assume that ticks arrive at least UIP_CYCLES+2 cycles apart, as a 1 Hz enable does. They also assume that every loaded byte is a legal encoding of a valid date and time under the mode bits in force, since the range check on the internal time relies on that. The bench spaces every tick by a full update window plus margin. It builds each load byte from a valid time, with the day of month drawn within the length of that month. It holds bin_i and h24_i steady from a load until the refresh has been checked.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [4:0] hour;
    logic [2:0] wday;
    logic [4:0] mday;
    logic [3:0] mon;
    logic [6:0] year;
  } rtc_time_t;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_bytes_t;

  localparam logic [2:0] OSC_RUN = 3'b010;

  function automatic logic [7:0] enc_byte(input logic [6:0] v, input logic bin);
    logic [6:0] t;
    t = v / 7'd10;
    return bin ? {1'b0, v} : {t[3:0], 4'(v - t * 7'd10)};
  endfunction

  function automatic logic [6:0] dec_byte(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : 7'({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                          input logic h24);
    logic [4:0] h12;
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h24) return enc_byte({2'b0, h}, bin);
    return enc_byte({2'b0, h12}, bin) | ((h >= 5'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                          input logic h24);
    logic [6:0] v;
    v = dec_byte({1'b0, b[6:0]}, bin);
    if (h24) return dec_byte(b, bin)[4:0];
    return v[4:0] + (b[7] ? 5'd12 : 5'd0);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yy);
    logic [15:0] full;
    logic        leap;
    full = 16'd2000 + {9'b0, yy};
    leap = (full % 16'd4 == 16'd0) &&
           ((full % 16'd100 != 16'd0) || (full % 16'd400 == 16'd0));
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return leap ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       load_i,
  input  rtc_bytes_t ld_i,
  input  logic       bin_i,
  input  logic       h24_i,
  output rtc_time_t  cur_o
);

  rtc_time_t cur_q, nxt, ld_t;

  always_comb begin
    nxt = cur_q;
    if (cur_q.sec >= 7'd59) begin
      nxt.sec = '0;
      if (cur_q.min >= 7'd59) begin
        nxt.min = '0;
        if (cur_q.hour >= 5'd23) begin
          nxt.hour = '0;
          nxt.wday = (cur_q.wday >= 3'd6) ? 3'd0 : cur_q.wday + 3'd1;
          if (cur_q.mday >= month_days(cur_q.mon, cur_q.year)) begin
            nxt.mday = 5'd1;
            if (cur_q.mon >= 4'd12) begin
              nxt.mon  = 4'd1;
              nxt.year = (cur_q.year >= 7'd99) ? 7'd0 : cur_q.year + 7'd1;
            end else begin
              nxt.mon = cur_q.mon + 4'd1;
            end
          end else begin
            nxt.mday = cur_q.mday + 5'd1;
          end
        end else begin
          nxt.hour = cur_q.hour + 5'd1;
        end
      end else begin
        nxt.min = cur_q.min + 7'd1;
      end
    end else begin
      nxt.sec = cur_q.sec + 7'd1;
    end
  end

  always_comb begin
    ld_t.sec  = dec_byte(ld_i.sec, bin_i);
    ld_t.min  = dec_byte(ld_i.min, bin_i);
    ld_t.hour = dec_hour(ld_i.hour, bin_i, h24_i);
    ld_t.wday = ld_i.wday[2:0];
    ld_t.mday = dec_byte(ld_i.mday, bin_i)[4:0];
    ld_t.mon  = dec_byte(ld_i.mon, bin_i)[3:0];
    ld_t.year = dec_byte(ld_i.year, bin_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '{sec: 7'd0, min: 7'd0, hour: 5'd0, wday: 3'd0,
                 mday: 5'd1, mon: 4'd1, year: 7'd0};
    end else if (load_i) begin
      cur_q <= ld_t;
    end else if (adv_i) begin
      cur_q <= nxt;
    end
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/rtc_encode.sv
module rtc_encode
  import rtc_pkg::*;
(
  input  rtc_time_t  t_i,
  input  logic       bin_i,
  input  logic       h24_i,
  output rtc_bytes_t b_o
);

  always_comb begin
    b_o.sec  = enc_byte(t_i.sec, bin_i);
    b_o.min  = enc_byte(t_i.min, bin_i);
    b_o.hour = enc_hour(t_i.hour, bin_i, h24_i);
    b_o.wday = {5'b0, t_i.wday};
    b_o.mday = enc_byte({2'b0, t_i.mday}, bin_i);
    b_o.mon  = enc_byte({3'b0, t_i.mon}, bin_i);
    b_o.year = enc_byte(t_i.year, bin_i);
  end

endmodule

// File: rtl/rtc_uip_timer.sv
module rtc_uip_timer #(
  parameter int unsigned UIP_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CW = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(UIP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_INIT;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned UIP_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] osc_sel_i,
  input  logic       set_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_wday_i,
  input  logic [7:0] ld_mday_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip_o
);

  rtc_bytes_t ld_b, enc_b, vis_q;
  rtc_time_t  cur_q;
  logic       adv, start, busy, done;

  assign ld_b  = '{sec: ld_sec_i, min: ld_min_i, hour: ld_hour_i, wday: ld_wday_i,
                   mday: ld_mday_i, mon: ld_mon_i, year: ld_year_i};
  assign adv   = tick_i && (osc_sel_i == OSC_RUN) && !load_i;
  assign start = adv && !set_i;

  rtc_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .load_i (load_i),
    .ld_i   (ld_b),
    .bin_i  (bin_i),
    .h24_i  (h24_i),
    .cur_o  (cur_q)
  );

  rtc_encode u_enc (
    .t_i   (cur_q),
    .bin_i (bin_i),
    .h24_i (h24_i),
    .b_o   (enc_b)
  );

  rtc_uip_timer #(.UIP_CYCLES(UIP_CYCLES)) u_uip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cancel_i (load_i),
    .busy_o   (busy),
    .done_o   (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h00,
                 mday: 8'h01, mon: 8'h01, year: 8'h00};
    end else if (load_i) begin
      vis_q <= ld_b;
    end else if (done && !set_i) begin
      vis_q <= enc_b;
    end
  end

  assign sec_o  = vis_q.sec;
  assign min_o  = vis_q.min;
  assign hour_o = vis_q.hour;
  assign wday_o = vis_q.wday;
  assign mday_o = vis_q.mday;
  assign mon_o  = vis_q.mon;
  assign year_o = vis_q.year;
  assign uip_o  = busy;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [2:0] osc_sel_i,
  input logic       set_i,
  input logic       load_i,
  input logic       uip_o,
  input rtc_bytes_t vis_i,
  input rtc_time_t  cur_i
);

  AST_UIP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && osc_sel_i == 3'b010 && !set_i && !load_i |=> uip_o); // R7

  AST_OSC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uip_o && osc_sel_i != 3'b010 && !load_i |=> !uip_o); // R6

  AST_SET_NO_UIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uip_o && set_i && !load_i |=> !uip_o); // R8

  AST_SET_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !load_i |=> $stable(vis_i)); // R8

  AST_LOAD_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !uip_o); // R9

  AST_VIS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uip_o && !load_i |=> $stable(vis_i)); // R10

  AST_TIME_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_i.sec < 7'd60 && cur_i.min < 7'd60 && cur_i.hour < 5'd24 &&
    cur_i.wday < 3'd7 && cur_i.mday >= 5'd1 && cur_i.mon >= 4'd1 &&
    cur_i.mon <= 4'd12 && cur_i.year < 7'd100); // R4

endmodule

bind rtc_calendar rtc_calendar_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .osc_sel_i (osc_sel_i),
  .set_i     (set_i),
  .load_i    (load_i),
  .uip_o     (uip_o),
  .vis_i     (vis_q),
  .cur_i     (cur_q)
);

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;

  localparam int UIPC = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] osc_sel_i = 3'b010;
  logic       set_i = 1'b0;
  logic       bin_i = 1'b0;
  logic       h24_i = 1'b1;
  logic       load_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_wday_i = '0;
  logic [7:0] ld_mday_i = '0, ld_mon_i = '0, ld_year_i = '0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
  logic       uip_o;

  always #2 clk = ~clk;

  rtc_calendar #(.UIP_CYCLES(UIPC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .osc_sel_i(osc_sel_i),
    .set_i(set_i), .bin_i(bin_i), .h24_i(h24_i), .load_i(load_i),
    .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i),
    .ld_wday_i(ld_wday_i), .ld_mday_i(ld_mday_i), .ld_mon_i(ld_mon_i),
    .ld_year_i(ld_year_i), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
    .uip_o(uip_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int ms, mm, mh, mw, md, mo, my;
  logic [55:0] vis_exp;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] benc(int v);
    if (bin_i) return 8'(v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic logic [7:0] benc_hour(int h);
    if (h24_i) return benc(h);
    return benc(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int bdays(int mon, int yy);
    int y = 2000 + yy;
    bit lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (mon == 2) return lp ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] model_bytes();
    return {benc(ms), benc(mm), benc_hour(mh), 8'(mw), benc(md), benc(mo), benc(my)};
  endfunction

  function automatic logic [55:0] vis_now();
    return {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
  endfunction

  task automatic model_next();
    ms++;
    if (ms < 60) return;
    ms = 0; mm++;
    if (mm < 60) return;
    mm = 0; mh++;
    if (mh < 24) return;
    mh = 0;
    mw = (mw + 1) % 7;
    md++;
    if (md <= bdays(mo, my)) return;
    md = 1; mo++;
    if (mo <= 12) return;
    mo = 1;
    my = (my + 1) % 100;
  endtask

  task automatic load_time(string req, int s, int m, int h, int w, int d, int mon, int y);
    logic [55:0] b;
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
    b = model_bytes();
    @(negedge clk);
    {ld_sec_i, ld_min_i, ld_hour_i, ld_wday_i, ld_mday_i, ld_mon_i, ld_year_i} = b;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    vis_exp = b;
    check({req, " load vis"}, {8'h0, vis_now()}, {8'h0, vis_exp});
    check({req, " load uip"}, {63'h0, uip_o}, 64'h0);
  endtask

  task automatic do_tick(string req);
    bit acc, upd;
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    acc = (osc_sel_i == 3'b010);
    upd = acc && !set_i;
    if (acc) model_next();
    check({req, " R7 uip rise"}, {63'h0, uip_o}, {63'h0, upd});
    repeat (UIPC - 1) @(negedge clk);
    check({req, " R7 uip hold"}, {63'h0, uip_o}, {63'h0, upd});
    check({req, " R7 vis before copy"}, {8'h0, vis_now()}, {8'h0, vis_exp});
    @(negedge clk);
    if (upd) vis_exp = model_bytes();
    check({req, " R7 uip fall"}, {63'h0, uip_o}, 64'h0);
    check({req, " vis after"}, {8'h0, vis_now()}, {8'h0, vis_exp});
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset vis", {8'h0, vis_now()}, {8'h0, 56'h00000000010100});
    check("R1 reset uip", {63'h0, uip_o}, 64'h0);
    ms = 0; mm = 0; mh = 0; mw = 0; md = 1; mo = 1; my = 0;
    vis_exp = 56'h00000000010100;

    // R2 BCD, R4 and R5 full rollover
    load_time("R2 bcd", 58, 59, 23, 6, 31, 12, 99);
    do_tick("R2 bcd 59");
    check("R2 bcd sec byte", {56'h0, sec_o}, {56'h0, 8'h59});
    do_tick("R4 R5 year wrap");
    check("R4 wday wrap", {56'h0, wday_o}, 64'h0);
    check("R5 year wrap", {8'h0, vis_now()}, {8'h0, 56'h00000000010100});

    // R5 leap rule
    load_time("R5 leap2000", 59, 59, 23, 1, 28, 2, 0);
    do_tick("R5 feb29 in 2000");
    check("R5 mday 29", {56'h0, mday_o}, {56'h0, 8'h29});
    load_time("R5 nonleap", 59, 59, 23, 2, 28, 2, 1);
    do_tick("R5 mar1 in 2001");
    check("R5 mon 3", {48'h0, mday_o, mon_o}, {48'h0, 16'h0103});
    load_time("R5 leap2004", 59, 59, 23, 3, 29, 2, 4);
    do_tick("R5 mar1 in 2004");
    load_time("R5 apr", 59, 59, 23, 4, 30, 4, 25);
    do_tick("R5 may1");
    check("R5 may", {48'h0, mday_o, mon_o}, {48'h0, 16'h0105});

    // R3 12-hour
    h24_i = 1'b0;
    load_time("R3 pm11", 59, 59, 23, 0, 15, 6, 30);
    check("R3 pm byte", {56'h0, hour_o}, {56'h0, 8'h91});
    do_tick("R3 midnight");
    check("R3 midnight byte", {56'h0, hour_o}, 64'h0);
    load_time("R3 am11", 59, 59, 11, 0, 15, 6, 30);
    do_tick("R3 noon");
    check("R3 noon byte", {56'h0, hour_o}, {56'h0, 8'h80});

    // R2 binary
    bin_i = 1'b1;
    load_time("R2 bin", 58, 45, 13, 5, 19, 11, 47);
    do_tick("R2 bin tick");
    check("R2 bin sec", {56'h0, sec_o}, {56'h0, 8'd59});
    check("R2 bin hour", {56'h0, hour_o}, {56'h0, 8'h81});
    bin_i = 1'b0; h24_i = 1'b1;

    // R6 oscillator gating
    load_time("R6 base", 10, 20, 5, 2, 7, 3, 12);
    osc_sel_i = 3'b000;
    do_tick("R6 gated 000");
    osc_sel_i = 3'b110;
    do_tick("R6 gated 110");
    osc_sel_i = 3'b010;
    do_tick("R6 run");
    check("R6 one second", {56'h0, sec_o}, {56'h0, 8'h11});

    // R8 set mode
    set_i = 1'b1;
    do_tick("R8 set tick1");
    do_tick("R8 set tick2");
    check("R8 frozen", {56'h0, sec_o}, {56'h0, 8'h11});
    set_i = 1'b0;
    do_tick("R8 after set");
    check("R8 counted", {56'h0, sec_o}, {56'h0, 8'h14});

    // R9 load priority and cancel
    ms = 30; mm = 0; mh = 0; mw = 0; md = 1; mo = 1; my = 50;
    @(negedge clk);
    {ld_sec_i, ld_min_i, ld_hour_i, ld_wday_i, ld_mday_i, ld_mon_i, ld_year_i} = model_bytes();
    load_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; tick_i = 1'b0;
    vis_exp = model_bytes();
    check("R9 priority vis", {8'h0, vis_now()}, {8'h0, vis_exp});
    check("R9 priority uip", {63'h0, uip_o}, 64'h0);
    repeat (UIPC + 2) @(negedge clk);
    check("R9 priority hold", {8'h0, vis_now()}, {8'h0, vis_exp});
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (2) @(negedge clk);
    load_time("R9 cancel", 40, 1, 2, 3, 4, 5, 6);
    repeat (UIPC + 2) @(negedge clk);
    check("R9 cancel hold", {8'h0, vis_now()}, {8'h0, vis_exp});
    check("R10 stable uip", {63'h0, uip_o}, 64'h0);
    repeat (5) @(negedge clk);
    check("R10 stable vis", {8'h0, vis_now()}, {8'h0, vis_exp});

    // random mix
    for (int i = 0; i < 40; i++) begin
      int s, m, h, mon, y, d;
      bin_i = 1'($urandom % 2);
      h24_i = 1'($urandom % 2);
      s = ($urandom % 3 == 0) ? 58 : int'($urandom % 60);
      m = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      h = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      mon = 1 + int'($urandom % 12);
      y = int'($urandom % 100);
      d = ($urandom % 2 == 0) ? bdays(mon, y) : 1 + int'($urandom % bdays(mon, y));
      load_time("R2 R3 rnd", s, m, h, int'($urandom % 7), d, mon, y);
      for (int k = 0; k < 3; k++) do_tick("R4 R5 rnd");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule